// File: doc/BRIEF.md
# Burst-Aware Round-Robin Slave Arbiter

This block sits in front of one shared slave port of a multi-master interconnect. Each master presents a request, a transfer kind, a per-beat valid flag and a last-beat flag. The arbiter grants the slave to at most one master at a time. It hands the slave over only at legal points: an idle grant, the owner releasing its request, a single transfer, the final beat of a fixed-length burst, or a predicted boundary inside an open-ended incrementing burst.

Two plain configuration inputs shape those points. The first selects where an open-ended burst is split. The second sets a slot budget in clock cycles; once the budget is spent, the current owner is cut off at its next beat.

The winner is picked round-robin, starting from the master after the one granted last. After reset the search starts at master 0, so the lowest index wins first. No default master is kept. When nobody requests, the grant goes to zero.

Top module: `rr_slave_arb`

## Requirements
- R1: After reset, when several masters request together, master 0 (the lowest index) is granted first.
- R2: At each arbitration point the new grant goes to the first requesting master after the last granted one, in increasing index order with wrap-around. This also holds after an interval with no grant.
- R3: An arbitration point at which no master requests leaves the grant at all zeros. While the grant is zero and no master requests, `rearb` stays low.
- R4: `grant` changes only at the clock edge that ends a cycle with `rearb` high. `rearb` is high in a cycle when the grant is zero and some master requests, or when the owner's request is low. It stays low while the owner requests with its valid flag low and no other point applies.
- R5: For an owner transfer kind of 0 (single), every valid beat is an arbitration point.
- R6: For kind 1 (fixed-length burst), the valid beat with the last flag set is an arbitration point, and earlier beats are not.
- R7: For kind 2 (open-ended incrementing burst), the split code sets the predicted end, counting valid beats from the start of the tenure. Code 0 never splits, code 1 splits at every beat, code 2 every 4 beats, code 3 every 8 beats and code 4 every 16 beats. A valid beat with the last flag set is always a point.
- R8: At each arbitration point a slot counter is loaded with `slot_limit`. It then decreases by one every cycle while a master holds the grant, and stops at zero. At zero, the next valid owner beat is an arbitration point. A `slot_limit` of 0 disables this cut.
- R9: A lone requesting master is granted again at an arbitration point with no gap cycle. Its beat count and slot count restart.
- R10: `grant` is always one-hot or all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_MST | Per-master request |
| burst_kind | input | N_MST x 2 | Per-master transfer kind: 0 single, 1 fixed burst, 2 open-ended incrementing burst |
| xfer_vld | input | N_MST | Per-master beat valid (a data beat completes) |
| xfer_last | input | N_MST | Per-master last-beat flag |
| split_sel | input | 3 | Predicted-end code for open-ended bursts |
| slot_limit | input | SLOT_W | Slot budget in cycles, 0 disables the cut |
| grant | output | N_MST | One-hot grant, all zeros when idle |
| rearb | output | 1 | High in each cycle that is an arbitration point |

## Verification
`rearb` is combinational from the current inputs and registered state, so it is due in the same cycle the beat is presented. `grant` is registered, so it shows the winner one rising edge after the cycle that pulsed `rearb`. The bench drives each cycle's inputs on the falling edge and queues the expected current grant and strobe for that cycle. The monitor compares them a quarter period later, well before the next rising edge. The hand-worked sequences therefore state, for every cycle, the grant that the previous cycle's decision produced.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
    localparam int BEAT_W = 4;

    typedef enum logic [1:0] {
        BK_SINGLE = 2'd0,
        BK_FIXED  = 2'd1,
        BK_OPEN   = 2'd2,
        BK_RSVD   = 2'd3
    } burst_kind_e;

    typedef enum logic [2:0] {
        SPLIT_NEVER = 3'd0,
        SPLIT_1     = 3'd1,
        SPLIT_4     = 3'd2,
        SPLIT_8     = 3'd3,
        SPLIT_16    = 3'd4
    } split_e;
endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int N_MST = 4,
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic [N_MST-1:0] req_i,
    input  logic [IDX_W-1:0] last_i,
    output logic [N_MST-1:0] gnt_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             any_o
);
    int cand;

    always_comb begin
        gnt_o = '0;
        idx_o = last_i;
        any_o = 1'b0;
        cand  = 0;
        for (int k = 1; k <= N_MST; k++) begin
            cand = (int'(last_i) + k) % N_MST;
            if (!any_o && req_i[cand]) begin
                gnt_o[cand] = 1'b1;
                idx_o       = IDX_W'(cand);
                any_o       = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_endpoint.sv
module arb_endpoint
    import rr_arb_pkg::*;
(
    input  logic              own_act_i,
    input  logic              own_req_i,
    input  logic              own_vld_i,
    input  logic              own_last_i,
    input  logic [1:0]        own_kind_i,
    input  logic [2:0]        split_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  logic              slot_on_i,
    input  logic              slot_zero_i,
    output logic              point_o
);
    logic pred_end;
    logic beat_end;
    logic cut;

    // predicted end inside an open-ended burst, beat_i counts completed beats
    always_comb begin
        case (split_e'(split_i))
            SPLIT_1:  pred_end = 1'b1;
            SPLIT_4:  pred_end = &beat_i[1:0];
            SPLIT_8:  pred_end = &beat_i[2:0];
            SPLIT_16: pred_end = &beat_i[3:0];
            default:  pred_end = 1'b0;
        endcase
    end

    always_comb begin
        case (burst_kind_e'(own_kind_i))
            BK_FIXED: beat_end = own_last_i;
            BK_OPEN:  beat_end = own_last_i | pred_end;
            default:  beat_end = 1'b1;
        endcase
    end

    assign cut = slot_on_i & slot_zero_i;

    always_comb begin
        if (!own_act_i || !own_req_i) begin
            point_o = 1'b1;
        end else begin
            point_o = own_vld_i & (beat_end | cut);
        end
    end
endmodule

// File: rtl/rr_slave_arb.sv
module rr_slave_arb
    import rr_arb_pkg::*;
#(
    parameter int N_MST  = 4,
    parameter int SLOT_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_MST-1:0]      req,
    input  logic [N_MST-1:0][1:0] burst_kind,
    input  logic [N_MST-1:0]      xfer_vld,
    input  logic [N_MST-1:0]      xfer_last,
    input  logic [2:0]            split_sel,
    input  logic [SLOT_W-1:0]     slot_limit,
    output logic [N_MST-1:0]      grant,
    output logic                  rearb
);
    localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

    typedef struct packed {
        logic [N_MST-1:0]  gnt;
        logic [IDX_W-1:0]  last;
        logic [BEAT_W-1:0] beat;
        logic [SLOT_W-1:0] slot;
        logic              slot_on;
    } arb_st_t;

    arb_st_t st_d, st_q;

    logic             own_act, own_req, own_vld, own_last;
    logic [1:0]       own_kind;
    logic             point;
    logic [N_MST-1:0] pick_gnt;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_any;

    // signals of the current owner
    always_comb begin
        own_req  = 1'b0;
        own_vld  = 1'b0;
        own_last = 1'b0;
        own_kind = '0;
        for (int m = 0; m < N_MST; m++) begin
            if (st_q.gnt[m]) begin
                own_req  = req[m];
                own_vld  = xfer_vld[m];
                own_last = xfer_last[m];
                own_kind = burst_kind[m];
            end
        end
    end

    assign own_act = |st_q.gnt;

    arb_endpoint u_endpoint (
        .own_act_i  (own_act),
        .own_req_i  (own_req),
        .own_vld_i  (own_vld),
        .own_last_i (own_last),
        .own_kind_i (own_kind),
        .split_i    (split_sel),
        .beat_i     (st_q.beat),
        .slot_on_i  (st_q.slot_on),
        .slot_zero_i(st_q.slot == '0),
        .point_o    (point)
    );

    arb_rr_pick #(.N_MST(N_MST)) u_pick (
        .req_i (req),
        .last_i(st_q.last),
        .gnt_o (pick_gnt),
        .idx_o (pick_idx),
        .any_o (pick_any)
    );

    assign rearb = point & (own_act | (|req));
    assign grant = st_q.gnt;

    always_comb begin
        st_d = st_q;
        if (rearb) begin
            st_d.gnt     = pick_gnt;
            st_d.beat    = '0;
            st_d.slot    = slot_limit;
            st_d.slot_on = |slot_limit;
            if (pick_any) begin
                st_d.last = pick_idx;
            end
        end else begin
            if (own_act && own_vld) begin
                st_d.beat = st_q.beat + 1'b1;
            end
            if (own_act && st_q.slot != '0) begin
                st_d.slot = st_q.slot - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gnt     <= '0;
            st_q.last    <= IDX_W'(N_MST - 1);
            st_q.beat    <= '0;
            st_q.slot    <= '0;
            st_q.slot_on <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rearb |=> $stable(grant));

    p_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb && req == '0) |=> grant == '0);

    p_served_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb && req != '0) |=> (grant & $past(req)) != '0);

    p_lone_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rearb && $countones(req) == 1) |=> grant == $past(req));
endmodule

// File: tb/tb_rr_slave_arb.sv
module tb_rr_slave_arb;
    localparam int CLK_P = 10;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic [N-1:0][1:0] kind = '0;
    logic [N-1:0]   vld = '0;
    logic [N-1:0]   lst = '0;
    logic [2:0]     split = '0;
    logic [7:0]     slim = '0;
    logic [N-1:0]   grant;
    logic           rearb;

    int total = 0;
    int bad = 0;
    bit done = 0;

    typedef struct {
        logic [N-1:0] g;
        logic         r;
        string        tag;
    } exp_t;
    exp_t q[$];

    rr_slave_arb #(.N_MST(N), .SLOT_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .req(req), .burst_kind(kind),
        .xfer_vld(vld), .xfer_last(lst), .split_sel(split),
        .slot_limit(slim), .grant(grant), .rearb(rearb)
    );

    always #(CLK_P/2) clk = ~clk;

    // driver: apply one cycle of inputs at the falling edge, queue expectation
    task automatic cyc(input logic [N-1:0] r, input logic [N-1:0] v,
                       input logic [N-1:0] l, input logic [N-1:0] eg,
                       input logic er, input string tag);
        @(negedge clk);
        req = r; vld = v; lst = l;
        q.push_back('{g: eg, r: er, tag: tag});
    endtask

    task automatic beats(input logic [N-1:0] r, input logic [N-1:0] g,
                         input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(r, g, '0, g, 1'b0, tag);
    endtask

    // monitor: compare a quarter period after the falling edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                e = q.pop_front();
                total++;
                if (grant !== e.g || rearb !== e.r) begin
                    bad++;
                    $display("FAIL %s: grant=%b rearb=%b expected grant=%b rearb=%b",
                             e.tag, grant, rearb, e.g, e.r);
                end
                total++;
                if ($countones(grant) > 1) begin
                    bad++;
                    $display("FAIL R10: grant=%b expected one-hot or zero", grant);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (grant !== '0 || rearb !== 1'b0) begin
            bad++;
            $display("FAIL R3 reset: grant=%b rearb=%b expected 0000 0", grant, rearb);
        end
        rst_n = 1'b1;

        // all single transfers: R1, R2, R5, R3
        kind = '0;
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 idle no strobe");
        cyc(4'b1111, 4'b0000, '0, 4'b0000, 1'b1, "R1 idle point");
        cyc(4'b1111, 4'b0001, '0, 4'b0001, 1'b1, "R1 lowest first R5");
        cyc(4'b1111, 4'b0010, '0, 4'b0010, 1'b1, "R2 order m1");
        cyc(4'b1111, 4'b0100, '0, 4'b0100, 1'b1, "R2 order m2");
        cyc(4'b1111, 4'b1000, '0, 4'b1000, 1'b1, "R2 order m3");
        cyc(4'b0000, 4'b0000, '0, 4'b0001, 1'b1, "R2 wrap R3 release");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");
        cyc(4'b1010, 4'b0000, '0, 4'b0000, 1'b1, "R2 after gap");
        cyc(4'b1010, 4'b0010, '0, 4'b0010, 1'b1, "R2 resume after m0");
        cyc(4'b0000, 4'b0000, '0, 4'b1000, 1'b1, "R2 skip m0 m2");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");

        // fixed bursts: R6, R4
        kind[0] = 2'd1; kind[1] = 2'd1;
        cyc(4'b0011, 4'b0000, '0, 4'b0000, 1'b1, "R2 pick m0");
        cyc(4'b0011, 4'b0001, '0, 4'b0001, 1'b0, "R6 mid beat");
        cyc(4'b0011, 4'b0000, '0, 4'b0001, 1'b0, "R4 wait no strobe");
        cyc(4'b0011, 4'b0001, '0, 4'b0001, 1'b0, "R6 mid beat");
        cyc(4'b0011, 4'b0001, 4'b0001, 4'b0001, 1'b1, "R6 last beat");
        cyc(4'b0011, 4'b0010, 4'b0010, 4'b0010, 1'b1, "R6 one-beat burst");
        cyc(4'b0000, 4'b0000, '0, 4'b0001, 1'b1, "R4 owner release");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");

        // open bursts split every 4: R7
        kind[2] = 2'd2; kind[3] = 2'd2; split = 3'd2;
        cyc(4'b1100, 4'b0000, '0, 4'b0000, 1'b1, "R2 pick m2");
        beats(4'b1100, 4'b0100, 3, "R7 split4 inner");
        cyc(4'b1100, 4'b0100, '0, 4'b0100, 1'b1, "R7 split4 boundary");
        beats(4'b1100, 4'b1000, 3, "R7 split4 inner");
        cyc(4'b1100, 4'b1000, '0, 4'b1000, 1'b1, "R7 split4 boundary");
        cyc(4'b0000, 4'b0000, '0, 4'b0100, 1'b1, "R3 release");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");

        // never split, slot limit 0: R7, R8
        split = 3'd0;
        cyc(4'b1100, 4'b0000, '0, 4'b0000, 1'b1, "R2 pick m3");
        beats(4'b1100, 4'b1000, 20, "R7 never R8 disabled");
        cyc(4'b1100, 4'b1000, 4'b1000, 4'b1000, 1'b1, "R7 last ends open burst");
        cyc(4'b0000, 4'b0000, '0, 4'b0100, 1'b1, "R3 release");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");

        // split every beat
        split = 3'd1;
        cyc(4'b1100, 4'b0000, '0, 4'b0000, 1'b1, "R2 pick m3");
        cyc(4'b1100, 4'b1000, '0, 4'b1000, 1'b1, "R7 split1");
        cyc(4'b1100, 4'b0100, '0, 4'b0100, 1'b1, "R7 split1");
        cyc(4'b0000, 4'b0000, '0, 4'b1000, 1'b1, "R3 release");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");

        // split every 8, lone master: R7, R9
        split = 3'd3;
        cyc(4'b0100, 4'b0000, '0, 4'b0000, 1'b1, "R2 pick m2");
        for (int t = 0; t < 2; t++) begin
            beats(4'b0100, 4'b0100, 7, "R7 split8 inner");
            cyc(4'b0100, 4'b0100, '0, 4'b0100, 1'b1, "R9 lone regrant split8");
        end
        cyc(4'b0000, 4'b0000, '0, 4'b0100, 1'b1, "R3 release");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");

        // split every 16
        split = 3'd4;
        cyc(4'b0100, 4'b0000, '0, 4'b0000, 1'b1, "R2 pick m2");
        beats(4'b0100, 4'b0100, 15, "R7 split16 inner");
        cyc(4'b0100, 4'b0100, '0, 4'b0100, 1'b1, "R7 split16 boundary R9");
        cyc(4'b0000, 4'b0000, '0, 4'b0100, 1'b1, "R3 release");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");

        // slot cut with limit 3: R8
        split = 3'd0; slim = 8'd3;
        cyc(4'b1100, 4'b0000, '0, 4'b0000, 1'b1, "R2 pick m3");
        beats(4'b1100, 4'b1000, 3, "R8 budget left");
        cyc(4'b1100, 4'b1000, '0, 4'b1000, 1'b1, "R8 slot cut");
        beats(4'b1100, 4'b0100, 3, "R8 budget reloaded");
        cyc(4'b1100, 4'b0000, '0, 4'b0100, 1'b0, "R8 zero waits for beat");
        cyc(4'b1100, 4'b0100, '0, 4'b0100, 1'b1, "R8 slot cut on beat");
        cyc(4'b0000, 4'b0000, '0, 4'b1000, 1'b1, "R3 release");
        cyc(4'b0000, 4'b0000, '0, 4'b0000, 1'b0, "R3 dropped");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule